// File: doc/BRIEF.md
# Status Flags and Branch Decision Unit

This block keeps a three-bit condition status (carry, zero, negative) for a small 16-bit processor. The status changes only when an ALU result is presented. When the processor offers a jump or branch, the block compares the held status against a mask and an expected-value pattern taken from the instruction. It then says whether control is transferred, and where to.

Each instruction holds a 16-bit immediate word after the opcode word. For an absolute jump, the target is that immediate word. For a relative branch, the immediate is a signed displacement added to the address that follows the immediate word. Either form can be a subroutine call. When a call is taken, the block also presents the return address together with a single-cycle push strobe, for the stack logic to store. Decode, the ALU and the stack memory are outside this block. All outputs are registered.

Top module: `flag_branch_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `status_flags` is 3'b000 and `br_taken` and `push_strobe` are 0.
- R2: When `alu_valid` is 1 on a clock edge, `status_flags` takes new values after that edge. Bit 0 (carry) copies `alu_carry`. Bit 1 (zero) is 1 exactly when `alu_result` is all zeros. Bit 2 (negative) copies `alu_result[15]`.
- R3: On an edge where `alu_valid` is 0, `status_flags` keeps its value, whatever the branch inputs are.
- R4: A request with `br_mask` equal to 3'b000 is always taken, whatever the status bits are.
- R5: A request is taken exactly when every status bit whose `br_mask` bit is 1 equals the matching `br_want` bit. Status bits whose mask bit is 0 have no effect on the decision.
- R6: For a taken request with `br_relative`=0 (jump), `br_target` equals `br_imm`.
- R7: For a taken request with `br_relative`=1 (branch), `br_target` equals `br_pc + 4 + br_imm`, modulo 2^16, with `br_imm` read as two's complement.
- R8: A taken request with `br_call`=1 raises `push_strobe` for one cycle, with `push_data` = `br_pc + 4` (mod 2^16). A call that is not taken, or a taken request that is not a call, leaves `push_strobe` at 0.
- R9: `br_taken` and `br_target` appear on the cycle after the edge that sampled `br_valid`=1. On cycles with no request, `br_taken` is 0.
- R10: When `alu_valid` and `br_valid` are both 1 on the same edge, the decision uses the status bits held before that edge's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_valid | input | 1 | An ALU result is present this cycle |
| alu_result | input | 16 | ALU result word |
| alu_carry | input | 1 | Carry out of the ALU |
| br_valid | input | 1 | A jump or branch request is present |
| br_relative | input | 1 | 0 = absolute jump, 1 = relative branch |
| br_call | input | 1 | The request is a subroutine call |
| br_mask | input | 3 | Per-flag test enable (bit0 carry, bit1 zero, bit2 negative) |
| br_want | input | 3 | Per-flag required value, same bit order |
| br_imm | input | 16 | Immediate word: target or signed displacement |
| br_pc | input | 16 | Byte address of the jump or branch opcode word |
| status_flags | output | 3 | Held status {negative, zero, carry} |
| br_taken | output | 1 | Control transfer happens |
| br_target | output | 16 | New program counter, valid with br_taken |
| push_strobe | output | 1 | Store return address, one cycle |
| push_data | output | 16 | Return address |

## Verification
The bound checker watches these rules on every cycle: the status update from each ALU result, the held status when no result is presented, that no decision appears without a request, that an all-zero mask is taken, that a jump target equals the immediate, and that no push occurs without a taken request. The bench scenarios are needed for the full mask and expected-value match over many status states. They also cover branch arithmetic with negative and wrapping displacements, calls that are refused, and the ordering when a flag update and a branch fall on the same edge.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int NFLAG = 3;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;

  typedef enum logic {
    XFER_ABS = 1'b0,
    XFER_REL = 1'b1
  } xfer_kind_e;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/fbu_flag_reg.sv
module fbu_flag_reg
  import fbu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] result,
  input  logic              carry_in,
  output flag_vec_t         flags_o
);
  flag_vec_t next_flags;

  always_comb begin
    next_flags        = flags_o;
    if (upd) begin
      next_flags[FLG_C] = carry_in;
      next_flags[FLG_Z] = (result == '0);
      next_flags[FLG_N] = result[DATA_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= next_flags;
  end
endmodule

// File: rtl/fbu_cond_eval.sv
module fbu_cond_eval
  import fbu_pkg::*;
(
  input  flag_vec_t flags,
  input  flag_vec_t mask,
  input  flag_vec_t want,
  output logic      pass
);
  flag_vec_t bit_ok;

  // each flag either ignored or required to equal its expected bit
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign bit_ok[i] = ~mask[i] | (flags[i] == want[i]);
  end

  assign pass = &bit_ok;
endmodule

// File: rtl/fbu_target_gen.sv
module fbu_target_gen
  import fbu_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DISP_W     = 16,
  parameter int INSN_BYTES = 2,
  parameter int IMM_BYTES  = 2
) (
  input  xfer_kind_e        kind,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] imm,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] ret_addr
);
  localparam int STEP = INSN_BYTES + IMM_BYTES;

  logic [ADDR_W-1:0] disp_ext;

  if (DISP_W < ADDR_W) begin : g_sext
    assign disp_ext = {{(ADDR_W-DISP_W){imm[DISP_W-1]}}, imm[DISP_W-1:0]};
  end else begin : g_full
    assign disp_ext = imm;
  end

  assign ret_addr = pc + ADDR_W'(STEP);
  assign target   = (kind == XFER_REL) ? (ret_addr + disp_ext) : imm;
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import fbu_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int DISP_W     = 16,
  parameter int INSN_BYTES = 2,
  parameter int IMM_BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_valid,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              br_valid,
  input  logic              br_relative,
  input  logic              br_call,
  input  logic [2:0]        br_mask,
  input  logic [2:0]        br_want,
  input  logic [ADDR_W-1:0] br_imm,
  input  logic [ADDR_W-1:0] br_pc,
  output logic [2:0]        status_flags,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target,
  output logic              push_strobe,
  output logic [ADDR_W-1:0] push_data
);
  flag_vec_t         flags_q;
  logic              cond_pass;
  logic [ADDR_W-1:0] next_target;
  logic [ADDR_W-1:0] next_ret;
  xfer_kind_e        kind;

  assign kind = br_relative ? XFER_REL : XFER_ABS;

  fbu_flag_reg #(.DATA_W(DATA_W)) i_flags (
    .clk     (clk),
    .rst     (rst),
    .upd     (alu_valid),
    .result  (alu_result),
    .carry_in(alu_carry),
    .flags_o (flags_q)
  );

  // decision reads the flags held before this edge's update
  fbu_cond_eval i_cond (
    .flags(flags_q),
    .mask (br_mask),
    .want (br_want),
    .pass (cond_pass)
  );

  fbu_target_gen #(
    .ADDR_W    (ADDR_W),
    .DISP_W    (DISP_W),
    .INSN_BYTES(INSN_BYTES),
    .IMM_BYTES (IMM_BYTES)
  ) i_tgt (
    .kind    (kind),
    .pc      (br_pc),
    .imm     (br_imm),
    .target  (next_target),
    .ret_addr(next_ret)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      br_taken    <= 1'b0;
      br_target   <= '0;
      push_strobe <= 1'b0;
      push_data   <= '0;
    end else begin
      br_taken    <= br_valid & cond_pass;
      push_strobe <= br_valid & cond_pass & br_call;
      if (br_valid) begin
        br_target <= next_target;
        push_data <= next_ret;
      end
    end
  end

  assign status_flags = flags_q;
endmodule

// File: rtl/fbu_checker.sv
module fbu_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              alu_valid,
  input logic [DATA_W-1:0] alu_result,
  input logic              alu_carry,
  input logic              br_valid,
  input logic              br_relative,
  input logic [2:0]        br_mask,
  input logic [ADDR_W-1:0] br_imm,
  input logic [2:0]        status_flags,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target,
  input logic              push_strobe
);
  // R2
  flag_update_chk: assert property (@(posedge clk) disable iff (rst)
    alu_valid |=> (status_flags == {$past(alu_result[DATA_W-1]),
                                    $past(alu_result == '0),
                                    $past(alu_carry)}));

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !alu_valid |=> $stable(status_flags));

  // R4
  always_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_mask == 3'b000) |=> br_taken);

  // R6
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !br_relative) |=> (!br_taken || br_target == $past(br_imm)));

  // R8
  push_needs_taken_chk: assert property (@(posedge clk) disable iff (rst)
    push_strobe |-> br_taken);

  // R9
  no_request_chk: assert property (@(posedge clk) disable iff (rst)
    !br_valid |=> !br_taken);
endmodule

bind flag_branch_unit fbu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fbu_chk (
  .clk         (clk),
  .rst         (rst),
  .alu_valid   (alu_valid),
  .alu_result  (alu_result),
  .alu_carry   (alu_carry),
  .br_valid    (br_valid),
  .br_relative (br_relative),
  .br_mask     (br_mask),
  .br_imm      (br_imm),
  .status_flags(status_flags),
  .br_taken    (br_taken),
  .br_target   (br_target),
  .push_strobe (push_strobe)
);

// File: tb/test_flag_branch_unit.sv
module test_flag_branch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alu_valid = 1'b0;
  logic [15:0] alu_result = '0;
  logic        alu_carry = 1'b0;
  logic        br_valid = 1'b0;
  logic        br_relative = 1'b0;
  logic        br_call = 1'b0;
  logic [2:0]  br_mask = '0;
  logic [2:0]  br_want = '0;
  logic [15:0] br_imm = '0;
  logic [15:0] br_pc = '0;
  logic [2:0]  status_flags;
  logic        br_taken;
  logic [15:0] br_target;
  logic        push_strobe;
  logic [15:0] push_data;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  typedef struct {
    logic [2:0]  flags;
    logic        taken;
    logic [15:0] target;
    logic        push;
    logic [15:0] pdata;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [2:0]  mflags = '0;

  always #10 clk = ~clk;

  flag_branch_unit i_flag_branch_unit (
    .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_result(alu_result),
    .alu_carry(alu_carry), .br_valid(br_valid), .br_relative(br_relative),
    .br_call(br_call), .br_mask(br_mask), .br_want(br_want), .br_imm(br_imm),
    .br_pc(br_pc), .status_flags(status_flags), .br_taken(br_taken),
    .br_target(br_target), .push_strobe(push_strobe), .push_data(push_data)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus at negedge, record expectation
  task automatic step(input bit av, input logic [15:0] res, input bit cy,
                      input bit bv, input bit rel, input bit call,
                      input logic [2:0] mask, input logic [2:0] want,
                      input logic [15:0] imm, input logic [15:0] pc,
                      input string req);
    exp_t e;
    bit   pass;
    alu_valid = av; alu_result = res; alu_carry = cy;
    br_valid = bv; br_relative = rel; br_call = call;
    br_mask = mask; br_want = want; br_imm = imm; br_pc = pc;
    pass    = (((mflags ^ want) & mask) == 3'b000);       // R5 with old flags (R10)
    e.taken = bv && pass;
    e.target = rel ? (pc + 16'd4 + imm) : imm;            // R6, R7
    e.push  = bv && pass && call;                          // R8
    e.pdata = pc + 16'd4;
    if (av) mflags = {res[15], res == 16'h0000, cy};       // R2
    e.flags = mflags;
    e.req   = req;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic set_flags(input logic [2:0] f);
    logic [15:0] r;
    r = f[2] ? 16'h8001 : (f[1] ? 16'h0000 : 16'h0042);
    step(1, r, f[0], 0, 0, 0, 3'b000, 3'b000, 16'h0, 16'h0, "R2");
  endtask

  // monitor: compare outputs just after each edge
  always @(posedge clk) begin
    #1;
    if (mon_on && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.req, "flags", 16'(status_flags), 16'(e.flags));
      check(e.req, "taken", 16'(br_taken), 16'(e.taken));
      check(e.req, "push", 16'(push_strobe), 16'(e.push));
      if (e.taken) check(e.req, "target", br_target, e.target);
      if (e.push)  check(e.req, "push_data", push_data, e.pdata);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values during reset
    check("R1", "flags in reset", 16'(status_flags), 16'h0);
    check("R1", "taken in reset", 16'(br_taken), 16'h0);
    check("R1", "push in reset", 16'(push_strobe), 16'h0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1", "flags after reset", 16'(status_flags), 16'h0);
    check("R1", "taken after reset", 16'(br_taken), 16'h0);
    @(negedge clk);
    mon_on = 1'b1;

    // R2: zero result with carry; negative result; plain positive
    step(1, 16'h0000, 1, 0, 0, 0, 3'b000, 3'b000, 16'h0, 16'h0, "R2");
    step(1, 16'hF000, 0, 0, 0, 0, 3'b000, 3'b000, 16'h0, 16'h0, "R2");
    step(1, 16'h7FFF, 1, 0, 0, 0, 3'b000, 3'b000, 16'h0, 16'h0, "R2");
    // R3: no ALU result, busy branch inputs, flags hold; R9 idle
    step(0, 16'h0000, 0, 0, 1, 1, 3'b111, 3'b000, 16'h1234, 16'h0100, "R3");
    step(0, 16'h8000, 0, 0, 0, 0, 3'b000, 3'b000, 16'h0, 16'h0, "R9");

    // R4: empty mask taken in several flag states
    for (int f = 0; f < 8; f++) begin
      if (f[1] && f[2]) continue;
      set_flags(3'(f));
      step(0, 16'h0, 0, 1, 0, 0, 3'b000, 3'(~f), 16'hBEEF, 16'h0200, "R4");
    end

    // R5: every mask/want pair in reachable flag states
    for (int f = 0; f < 8; f++) begin
      if (f[1] && f[2]) continue;
      set_flags(3'(f));
      for (int m = 0; m < 8; m++)
        for (int w = 0; w < 8; w++)
          step(0, 16'h0, 0, 1, 0, 0, 3'(m), 3'(w), 16'(m*16+w), 16'h0300, "R5");
    end

    // R6: absolute jump
    step(0, 16'h0, 0, 1, 0, 0, 3'b000, 3'b000, 16'hA5C3, 16'h4000, "R6");
    // R7: forward, backward and wrapping displacements
    step(0, 16'h0, 0, 1, 1, 0, 3'b000, 3'b000, 16'h0010, 16'h1000, "R7");
    step(0, 16'h0, 0, 1, 1, 0, 3'b000, 3'b000, 16'hFFF0, 16'h1000, "R7");
    step(0, 16'h0, 0, 1, 1, 0, 3'b000, 3'b000, 16'h0020, 16'hFFF0, "R7");
    // R8: taken call (jump and branch), refused call, back-to-back
    set_flags(3'b001);
    step(0, 16'h0, 0, 1, 0, 1, 3'b001, 3'b001, 16'h2222, 16'h0500, "R8");
    step(0, 16'h0, 0, 0, 0, 0, 3'b000, 3'b000, 16'h0, 16'h0, "R8");
    step(0, 16'h0, 0, 1, 1, 1, 3'b001, 3'b001, 16'hFFFC, 16'hFFFE, "R8");
    step(0, 16'h0, 0, 1, 1, 1, 3'b001, 3'b000, 16'h0040, 16'h0600, "R8");
    step(0, 16'h0, 0, 1, 0, 1, 3'b000, 3'b000, 16'h3333, 16'h0700, "R8");
    // R10: same-edge update and branch use old flags
    set_flags(3'b000);
    step(1, 16'h0000, 1, 1, 0, 0, 3'b011, 3'b000, 16'h0A0A, 16'h0800, "R10");
    step(1, 16'h0042, 0, 1, 0, 0, 3'b011, 3'b011, 16'h0B0B, 16'h0900, "R10");
    step(0, 16'h0, 0, 1, 0, 0, 3'b011, 3'b000, 16'h0C0C, 16'h0A00, "R10");
    step(0, 16'h0, 0, 0, 0, 0, 3'b000, 3'b000, 16'h0, 16'h0, "R9");
    @(negedge clk);
    if (sb.size() != 0) check("R9", "scoreboard drained", 16'(sb.size()), 16'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule